// File: doc/BRIEF.md
# Sleep Wakeup Delay Sequencer

This block sequences a core's return from a low-power sleep state. It holds one retained configuration bit, the fast-wakeup enable, in a 32-bit register that software reaches over a simple register bus. A sleep request removes the run-ready indication. The core supply enable is dropped during sleep only when fast wakeup is clear. While the block sleeps with fast wakeup set, it asks for the oscillator to stay on.

On a wake event, the path depends on the configuration bit. With the bit clear, the supply is switched back on and the block counts a programmable number of millisecond tick pulses so the supply can settle. It then reports run-ready. With the bit set, the supply was never removed, so run-ready returns on the very next cycle. The configuration bit survives any number of sleep/wake cycles. Only the hardware, GPIO and watchdog reset inputs clear it. Software may clear the bit ahead of a power-fault sleep so that the supply is allowed to drop.

Top module: `slp_wake_seq`

## Requirements
- R1: After any reset, run_ready=1, supply_en=1, osc_keep_on=0 and reg_rdata=0.
- R2: A bus write (reg_en=1, reg_we=1) stores reg_wdata bit 1 as the fast-wakeup bit. reg_rdata shows that bit at bit 1, and every other bit reads 0 whatever was written.
- R3: A sleep request taken while run_ready=1 clears run_ready on the next cycle. supply_en falls on that cycle if the fast bit is 0, and stays 1 if the fast bit is 1.
- R4: osc_keep_on is 1 only while the block sleeps with the fast bit set.
- R5: With the fast bit 0, a wake event during sleep raises supply_en on the next cycle. run_ready stays 0 until the edge that samples the DELAY_MS-th ms_tick counted after the wake, and is 1 right after that edge.
- R6: With the fast bit 1, a wake event during sleep sets run_ready on the next cycle.
- R7: A sleep/wake cycle leaves the fast bit unchanged.
- R8: gpio_rst_n=0 or wdog_rst_n=0 clears the fast bit and returns the block to the running state on the next cycle.
- R9: Some inputs have no effect: a wake event while running, a sleep request during supply settling, and ms_tick pulses received before the wake event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| gpio_rst_n | input | 1 | GPIO reset, synchronous, active low |
| wdog_rst_n | input | 1 | Watchdog reset, synchronous, active low |
| reg_en | input | 1 | Register bus select |
| reg_we | input | 1 | Register bus write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| sleep_req | input | 1 | Sleep entry strobe |
| wake_evt | input | 1 | Wake event strobe |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| supply_en | output | 1 | Core supply enable |
| run_ready | output | 1 | Core may run |
| osc_keep_on | output | 1 | Request to keep the oscillator running in sleep |

## Verification
Register writes, sleep requests, wake events and reset pulses each change their outputs one clock edge after the cycle in which they are driven. On the slow path, run_ready rises one edge after the final counted tick. The bench tags each expected value with the cycle in which it is due. A scoreboard monitor compares those entries shortly after the matching rising edge, so each result is compared in its due cycle and neither earlier nor later. Tick pulses sent during sleep and strobes sent in the wrong state are checked through the same due-cycle mechanism, and the bench confirms that run_ready and supply_en still move at the expected edge.

// File: rtl/slpw_pkg.sv
// Shared types for the sleep wakeup sequencer.
// Assumes: one state encoding is shared by the controller and the checker.
package slpw_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_STAB  = 2'd2,
        ST_READY = 2'd3
    } slpw_state_e;

    // Bit position of the fast-wakeup enable in the configuration word.
    localparam int FAST_POS = 1;

endpackage

// File: rtl/slpw_cfg_reg.sv
// Configuration register that holds the retained fast-wakeup bit.
// Assumes: srst_n combines every true reset source, and reserved bits read as zero.
module slpw_cfg_reg #(
    parameter int DATA_W   = 32,
    parameter int FAST_POS = slpw_pkg::FAST_POS
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              fast_q,
    output logic [DATA_W-1:0] rdata
);

    logic unused_wdata;

    // Capture the enable bit on a bus write; the bit is cleared only by reset.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            fast_q <= 1'b0;
        end else if (wr_en) begin
            fast_q <= wdata[FAST_POS];
        end
    end

    // Build the read word, leaving every reserved bit at zero.
    always_comb begin
        rdata           = '0;
        rdata[FAST_POS] = fast_q;
    end

    // The reserved write bits carry no function.
    assign unused_wdata = ^wdata;

endmodule

// File: rtl/slpw_settle_cnt.sv
// Counts millisecond ticks while the supply settles and flags the final tick.
// Assumes: active stays high for the whole settling phase, and the count restarts at zero each time.
module slpw_settle_cnt #(
    parameter int DELAY_TICKS = 10
) (
    input  logic clk,
    input  logic srst_n,
    input  logic active,
    input  logic tick,
    output logic done
);

    localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;

    generate
        if (DELAY_TICKS == 0) begin : g_no_delay
            // A zero-length delay finishes as soon as settling starts.
            assign done = active;
        end else begin : g_delay
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);
            logic [CNT_W-1:0] cnt_q;

            // Advance on each tick during settling, and hold at zero otherwise.
            always_ff @(posedge clk) begin
                if (!srst_n || !active) begin
                    cnt_q <= '0;
                end else if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            // The final tick completes the settling interval.
            assign done = active && tick && (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/slpw_fsm.sv
// Sleep/wake state controller. Decodes supply, oscillator and ready outputs.
// Assumes: sleep_req and wake_evt are single-cycle strobes, and settle_done comes from the tick counter.
module slpw_fsm
    import slpw_pkg::*;
(
    input  logic        clk,
    input  logic        srst_n,
    input  logic        sleep_req,
    input  logic        wake_evt,
    input  logic        fast,
    input  logic        settle_done,
    output slpw_state_e state_o,
    output logic        run_ready,
    output logic        supply_en,
    output logic        osc_keep_on
);

    slpw_state_e state_q, state_d;

    // Choose the next state from the current state and the strobes.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_READY: begin
                if (sleep_req)          state_d = ST_SLEEP;
                else if (state_q == ST_READY) state_d = ST_RUN;
            end
            ST_SLEEP: begin
                if (wake_evt)           state_d = fast ? ST_READY : ST_STAB;
            end
            ST_STAB: begin
                if (settle_done)        state_d = ST_READY;
            end
            default:                    state_d = ST_RUN;
        endcase
    end

    // State register; every reset source returns the block to RUN.
    always_ff @(posedge clk) begin
        if (!srst_n) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    // Drive the outputs from the state and the retained fast bit.
    always_comb begin
        run_ready   = (state_q == ST_RUN) || (state_q == ST_READY);
        supply_en   = !((state_q == ST_SLEEP) && !fast);
        osc_keep_on = (state_q == ST_SLEEP) && fast;
    end

    assign state_o = state_q;

endmodule

// File: rtl/slp_wake_seq.sv
// Top level of the sleep wakeup delay sequencer.
// Assumes: all three resets are synchronous and active low, and ms_tick is one cycle wide.
module slp_wake_seq
    import slpw_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DELAY_MS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gpio_rst_n,
    input  logic              wdog_rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sleep_req,
    input  logic              wake_evt,
    input  logic              ms_tick,
    output logic              supply_en,
    output logic              run_ready,
    output logic              osc_keep_on
);

    logic        srst_n;
    logic        fast_q;
    logic        settle_done;
    logic        in_sleep;
    logic        in_stab;
    slpw_state_e cur_state;

    // Combine the true reset sources; wakeup itself never resets.
    assign srst_n = rst_n && gpio_rst_n && wdog_rst_n;

    slpw_cfg_reg #(
        .DATA_W  (DATA_W),
        .FAST_POS(FAST_POS)
    ) u_cfg (
        .clk   (clk),
        .srst_n(srst_n),
        .wr_en (reg_en && reg_we),
        .wdata (reg_wdata),
        .fast_q(fast_q),
        .rdata (reg_rdata)
    );

    slpw_settle_cnt #(
        .DELAY_TICKS(DELAY_MS)
    ) u_cnt (
        .clk   (clk),
        .srst_n(srst_n),
        .active(in_stab),
        .tick  (ms_tick),
        .done  (settle_done)
    );

    slpw_fsm u_fsm (
        .clk        (clk),
        .srst_n     (srst_n),
        .sleep_req  (sleep_req),
        .wake_evt   (wake_evt),
        .fast       (fast_q),
        .settle_done(settle_done),
        .state_o    (cur_state),
        .run_ready  (run_ready),
        .supply_en  (supply_en),
        .osc_keep_on(osc_keep_on)
    );

    // State flags shared by the counter and the checker.
    assign in_sleep = (cur_state == ST_SLEEP);
    assign in_stab  = (cur_state == ST_STAB);

endmodule

// File: rtl/slpw_checker.sv
// Property checker for the sleep wakeup sequencer, attached by bind.
// Assumes: the internal flags fast_q, in_sleep and in_stab are visible in the top scope.
module slpw_checker (
    input logic clk,
    input logic rst_n,
    input logic gpio_rst_n,
    input logic wdog_rst_n,
    input logic reg_en,
    input logic reg_we,
    input logic sleep_req,
    input logic wake_evt,
    input logic ms_tick,
    input logic supply_en,
    input logic run_ready,
    input logic osc_keep_on,
    input logic fast_q,
    input logic in_sleep,
    input logic in_stab
);

    logic soft_ok;
    logic no_wr;
    assign soft_ok = gpio_rst_n && wdog_rst_n;
    assign no_wr   = !(reg_en && reg_we);

    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ready && sleep_req && soft_ok) |=> !run_ready);

    a_r3_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ready && sleep_req && !fast_q && no_wr && soft_ok) |=> !supply_en);

    a_r3_supply_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ready && sleep_req && fast_q && no_wr && soft_ok) |=> supply_en);

    a_r4_osc_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        osc_keep_on |-> (fast_q && !run_ready));

    a_r5_wake_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && wake_evt && soft_ok) |=> supply_en);

    a_r5_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stab && !ms_tick && soft_ok) |=> !run_ready);

    a_r6_fast_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && wake_evt && fast_q && soft_ok) |=> run_ready);

    a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (no_wr && soft_ok) |=> $stable(fast_q));

    a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_ok) |=> (!fast_q && run_ready && supply_en));

endmodule

bind slp_wake_seq slpw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gpio_rst_n (gpio_rst_n),
    .wdog_rst_n (wdog_rst_n),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .sleep_req  (sleep_req),
    .wake_evt   (wake_evt),
    .ms_tick    (ms_tick),
    .supply_en  (supply_en),
    .run_ready  (run_ready),
    .osc_keep_on(osc_keep_on),
    .fast_q     (fast_q),
    .in_sleep   (in_sleep),
    .in_stab    (in_stab)
);

// File: tb/slp_wake_seq_tb.sv
// Scoreboard bench: the driver queues expected values with a due cycle, and the monitor compares them.
module slp_wake_seq_tb;

    localparam int TB_DELAY = 4;
    localparam int SIG_RDY = 0, SIG_SUP = 1, SIG_OSC = 2, SIG_RD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, gpio_rst_n = 1'b1, wdog_rst_n = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sleep_req = 1'b0, wake_evt = 1'b0, ms_tick = 1'b0;
    logic        supply_en, run_ready, osc_keep_on;

    typedef struct {
        int          due;
        int          sig;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;

    always #4 clk = ~clk;

    slp_wake_seq #(.DATA_W(32), .DELAY_MS(TB_DELAY)) u_dut (
        .clk(clk), .rst_n(rst_n), .gpio_rst_n(gpio_rst_n), .wdog_rst_n(wdog_rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sleep_req(sleep_req), .wake_evt(wake_evt), .ms_tick(ms_tick),
        .supply_en(supply_en), .run_ready(run_ready), .osc_keep_on(osc_keep_on)
    );

    function automatic logic [31:0] sample(input int s);
        case (s)
            SIG_RDY: return {31'b0, run_ready};
            SIG_SUP: return {31'b0, supply_en};
            SIG_OSC: return {31'b0, osc_keep_on};
            default: return reg_rdata;
        endcase
    endfunction

    // Driver side: queue an expected value due d edges from now.
    task automatic expect_at(input int d, input int s, input logic [31:0] v, input string r);
        exp_t e;
        e.due = cyc + d; e.sig = s; e.val = v; e.req = r;
        q.push_back(e);
    endtask

    // Advance to the next falling edge and return all strobes to idle.
    task automatic step();
        @(negedge clk);
        sleep_req = 1'b0; wake_evt = 1'b0; ms_tick = 1'b0;
        reg_en = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        gpio_rst_n = 1'b1; wdog_rst_n = 1'b1;
    endtask

    task automatic reg_write(input logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_wdata = d;
        expect_at(1, SIG_RD, {30'b0, d[1], 1'b0}, "R2");
        step();
    endtask

    // Monitor: compare every entry that is due shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc = cyc + 1;
            #2;
            for (int i = 0; i < q.size(); ) begin
                if (q[i].due <= cyc) begin
                    logic [31:0] act;
                    act = sample(q[i].sig);
                    n_checks = n_checks + 1;
                    if (act !== q[i].val) begin
                        n_errors = n_errors + 1;
                        $display("FAIL %s signal %0d cycle %0d: actual %h expected %h",
                                 q[i].req, q[i].sig, cyc, act, q[i].val);
                    end
                    q.delete(i);
                end else begin
                    i = i + 1;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        n_errors = n_errors + 1;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        expect_at(1, SIG_RDY, 1, "R1");
        expect_at(1, SIG_SUP, 1, "R1");
        expect_at(1, SIG_OSC, 0, "R1");
        expect_at(1, SIG_RD, 0, "R1");
        step();

        // R2: only bit 1 is stored, and reserved bits read as zero
        reg_write(32'hFFFF_FFFD);
        reg_write(32'hFFFF_FFFF);
        reg_write(32'h0000_0000);

        // R3/R4: slow-path sleep drops the supply without an oscillator request
        sleep_req = 1'b1;
        expect_at(1, SIG_RDY, 0, "R3");
        expect_at(1, SIG_SUP, 0, "R3");
        expect_at(1, SIG_OSC, 0, "R4");
        step();
        // R9: ticks before the wake event are not counted
        ms_tick = 1'b1; expect_at(1, SIG_RDY, 0, "R9"); step();
        ms_tick = 1'b1; step();
        // R5: wake raises the supply while run_ready stays low
        wake_evt = 1'b1;
        expect_at(1, SIG_SUP, 1, "R5");
        expect_at(1, SIG_RDY, 0, "R5");
        expect_at(1, SIG_OSC, 0, "R4");
        step();
        // R9: a sleep request during settling is ignored
        sleep_req = 1'b1; expect_at(1, SIG_SUP, 1, "R9"); step();
        for (int i = 1; i <= TB_DELAY; i++) begin
            ms_tick = 1'b1;
            expect_at(1, SIG_RDY, (i == TB_DELAY) ? 32'd1 : 32'd0, "R5");
            step();
            if (i < TB_DELAY) step();
        end
        expect_at(1, SIG_RDY, 1, "R5");
        step();
        // R9: a wake event while running changes nothing
        wake_evt = 1'b1;
        expect_at(1, SIG_RDY, 1, "R9");
        expect_at(1, SIG_SUP, 1, "R9");
        step();
        expect_at(1, SIG_RDY, 1, "R9");
        step();

        // Fast path
        reg_write(32'h0000_0002);
        sleep_req = 1'b1;
        expect_at(1, SIG_RDY, 0, "R3");
        expect_at(1, SIG_SUP, 1, "R3");
        expect_at(1, SIG_OSC, 1, "R4");
        step();
        expect_at(1, SIG_OSC, 1, "R4");
        step();
        wake_evt = 1'b1;
        expect_at(1, SIG_RDY, 1, "R6");
        expect_at(1, SIG_OSC, 0, "R4");
        expect_at(1, SIG_SUP, 1, "R6");
        step();
        // R7: the fast bit survives the cycle
        expect_at(1, SIG_RD, 32'h2, "R7");
        step();

        // R8: GPIO reset during sleep
        sleep_req = 1'b1; expect_at(1, SIG_OSC, 1, "R4"); step();
        gpio_rst_n = 1'b0;
        expect_at(1, SIG_RDY, 1, "R8");
        expect_at(1, SIG_RD, 0, "R8");
        expect_at(1, SIG_OSC, 0, "R8");
        step();

        // R8: watchdog reset during sleep
        reg_write(32'h0000_0002);
        sleep_req = 1'b1; expect_at(1, SIG_RDY, 0, "R3"); step();
        wdog_rst_n = 1'b0;
        expect_at(1, SIG_RDY, 1, "R8");
        expect_at(1, SIG_RD, 0, "R8");
        expect_at(1, SIG_SUP, 1, "R8");
        step();

        repeat (4) step();
        if (q.size() != 0) begin
            n_errors = n_errors + 1;
            $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule